// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from reset to a usable state before the main memory controller gets the command bus. After reset it holds a start-up pause in which the command pins show NOP and the clock-enable and data-mask pins stay high, so the memory cannot drive its data bus. After the pause it issues a precharge of every bank. A fixed number of auto-refresh commands follow, and then one mode register load carries a configured mode word on the address pins.

Each command is followed by a wait set in clock cycles by a parameter. The pause length comes from the clock frequency in MHz times the pause in microseconds. After the wait that follows the mode register load, a ready flag rises and stays high until reset. The main controller waits for that flag before it takes over the pins. All pins are registered. A synchronous active-high reset restarts the whole sequence at any point.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high, and in the cycle after the last reset edge, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111), clock enable and every data-mask lane are high, and the ready flag is low.
- R2: After the last clock edge at which reset is high, the command pins show only NOP for PAUSE_CYC = CLK_MHZ*PAUSE_US cycles. The first other command appears exactly PAUSE_CYC cycles after that edge.
- R3: Clock enable and every data-mask lane stay high in every cycle of the sequence and after it.
- R4: The first command after the pause is precharge-all: 4'b0010 with address bit 10 high.
- R5: Exactly REF_COUNT auto-refresh commands (4'b0001) are issued. The first one comes T_RP cycles after the precharge, and each following one comes T_RC cycles after the one before it.
- R6: The mode register load (4'b0000) comes T_RC cycles after the last auto-refresh. During that cycle the address pins carry MODE_VALUE and the bank pins are zero.
- R7: Every cycle between two commands, and every cycle after the mode register load, shows NOP. No encoding other than NOP, precharge, refresh and mode load is ever driven.
- R8: The ready flag rises T_RSC cycles after the mode register load appears and stays high until reset.
- R9: Reset asserted at any point, including after ready, drops ready and restarts the sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdCke | output | 1 | Clock enable |
| sdDqm | output | DQM_W | Data-mask lanes |
| sdBank | output | BANK_W | Bank select |
| sdAddr | output | ADDR_W | Address / mode word |
| initDone | output | 1 | Sequence complete, handover to the controller |

## Verification
Some rules are checked by the assertions on every cycle:
- only the four legal encodings appear;
- clock enable and data mask stay high;
- a precharge always has bit 10 set;
- the mode load carries the configured word, only after every refresh and never before the pause has elapsed;
- the ready flag stays high and the bus stays quiet once ready.

The exact spacing between commands can only be shown by the bench's cycle-by-cycle walk against a schedule computed from the parameters. The same holds for the cycle in which ready rises and for a restart after reset in the middle of the sequence.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_READY
  } state_e;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic setReady;
  } strobe_t;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    waitDone,
  input  logic    lastRef,
  output strobe_t strb
);

  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_PAUSE: if (waitDone) begin
        strb.issuePre = 1'b1;
        stateD        = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (waitDone) begin
        strb.issueRef = 1'b1;
        stateD        = ST_REF_WAIT;
      end
      ST_REF_WAIT: if (waitDone) begin
        if (lastRef) begin
          strb.issueMrs = 1'b1;
          stateD        = ST_MRS_WAIT;
        end else begin
          strb.issueRef = 1'b1;
        end
      end
      ST_MRS_WAIT: if (waitDone) begin
        strb.setReady = 1'b1;
        stateD        = ST_READY;
      end
      ST_READY: stateD = ST_READY;
      default:  stateD = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_PAUSE;
    else     stateQ <= stateD;
  end

endmodule

// File: rtl/sdinit_datapath.sv
module sdinit_datapath
  import sdinit_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 200,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_RSC     = 2,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 1,
  parameter int DQM_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h030
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  output logic              waitDone,
  output logic              lastRef,
  output logic [3:0]        cmdBits,
  output logic [BANK_W-1:0] bankOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              ckeOut,
  output logic [DQM_W-1:0]  dqmOut,
  output logic              readyOut
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int MAX_AB    = (PAUSE_CYC > T_RC) ? PAUSE_CYC : T_RC;
  localparam int MAX_CD    = (T_RP > T_RSC) ? T_RP : T_RSC;
  localparam int MAX_WAIT  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);
  localparam int REF_W     = $clog2(REF_COUNT + 1);
  localparam int AP_BIT    = 10;
  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = {{(ADDR_W-1){1'b0}}, 1'b1} << AP_BIT;

  logic [CNT_W-1:0]  waitCnt;
  logic [REF_W-1:0]  refCnt;
  cmd_e              cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              holdHigh;
  logic              readyQ;

  // shared down-counter for every wait
  always_ff @(posedge clk) begin
    if (rst)                waitCnt <= CNT_W'(PAUSE_CYC - 1);
    else if (strb.issuePre) waitCnt <= CNT_W'(T_RP - 1);
    else if (strb.issueRef) waitCnt <= CNT_W'(T_RC - 1);
    else if (strb.issueMrs) waitCnt <= CNT_W'(T_RSC - 1);
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                refCnt <= '0;
    else if (strb.issueRef) refCnt <= refCnt + 1'b1;
  end

  assign waitDone = (waitCnt == '0);
  assign lastRef  = (refCnt == REF_W'(REF_COUNT));

  // registered pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ     <= CMD_NOP;
      addrQ    <= '0;
      holdHigh <= 1'b1;
      readyQ   <= 1'b0;
    end else begin
      holdHigh <= 1'b1;
      if (strb.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= PRE_ALL_ADDR;
      end else if (strb.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
      end else if (strb.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= MODE_VALUE;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
      if (strb.setReady) readyQ <= 1'b1;
    end
  end

  assign cmdBits  = cmdQ;
  assign addrOut  = addrQ;
  assign bankOut  = '0;
  assign ckeOut   = holdHigh;
  assign readyOut = readyQ;

  for (genvar lane = 0; lane < DQM_W; lane++) begin : g_dqm
    assign dqmOut[lane] = holdHigh;
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdinit_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 200,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_RSC     = 2,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 1,
  parameter int DQM_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h030
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdCke,
  output logic [DQM_W-1:0]  sdDqm,
  output logic [BANK_W-1:0] sdBank,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  strobe_t    strb;
  logic       waitDone;
  logic       lastRef;
  logic [3:0] cmdBits;

  sdinit_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .waitDone (waitDone),
    .lastRef  (lastRef),
    .strb     (strb)
  );

  sdinit_datapath #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_RSC(T_RSC), .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .DQM_W(DQM_W), .MODE_VALUE(MODE_VALUE)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .waitDone (waitDone),
    .lastRef  (lastRef),
    .cmdBits  (cmdBits),
    .bankOut  (sdBank),
    .addrOut  (sdAddr),
    .ckeOut   (sdCke),
    .dqmOut   (sdDqm),
    .readyOut (initDone)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdBits;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 200,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 1,
  parameter int DQM_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h030
) (
  input logic              clk,
  input logic              rst,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic              sdCke,
  input logic [DQM_W-1:0]  sdDqm,
  input logic [BANK_W-1:0] sdBank,
  input logic [ADDR_W-1:0] sdAddr,
  input logic              initDone
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;

  logic [3:0] cmd;
  int         sinceRst;
  int         refSeen;

  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= 0;
      refSeen  <= 0;
    end else begin
      if (sinceRst < PAUSE_CYC) sinceRst <= sinceRst + 1;
      if (cmd == 4'b0001)       refSeen  <= refSeen + 1;
    end
  end

  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000); // R7
  AST_GUARD_HIGH: assert property (@(posedge clk) disable iff (rst)
    sdCke && (sdDqm == {DQM_W{1'b1}})); // R3
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd != 4'b0111 |-> sinceRst >= PAUSE_CYC); // R2
  AST_PRE_ALL: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |-> sdAddr[10]); // R4
  AST_MODE_WORD: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0000 |-> (sdAddr == MODE_VALUE) && (sdBank == '0)); // R6
  AST_REFS_BEFORE_MODE: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0000 |-> refSeen == REF_COUNT); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    initDone |-> cmd == 4'b0111); // R7

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .REF_COUNT(REF_COUNT),
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQM_W(DQM_W), .MODE_VALUE(MODE_VALUE)
) chk_i (
  .clk(clk), .rst(rst), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdCke(sdCke), .sdDqm(sdDqm), .sdBank(sdBank),
  .sdAddr(sdAddr), .initDone(initDone)
);

// File: tb/sdram_powerup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb_top;

  localparam int CLK_MHZ   = 1;
  localparam int PAUSE_US  = 20;
  localparam int T_RP      = 3;
  localparam int T_RC      = 7;
  localparam int T_RSC     = 2;
  localparam int REF_COUNT = 8;
  localparam int ADDR_W    = 12;
  localparam int BANK_W    = 2;
  localparam int DQM_W     = 2;
  localparam logic [ADDR_W-1:0] MODE = 12'h032;

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int NEV       = 10;
  localparam int MRS_CYC   = PAUSE_CYC + T_RP + REF_COUNT * T_RC;
  localparam int DONE_CYC  = MRS_CYC + T_RSC;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  // expected schedule: cycle of each command and its encoding
  localparam int EV_CYC [NEV] = '{20, 23, 30, 37, 44, 51, 58, 65, 72, 79};
  localparam logic [3:0] EV_CMD [NEV] = '{PRE, REF, REF, REF, REF, REF, REF, REF, REF, MRS};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdCsN, sdRasN, sdCasN, sdWeN, sdCke, initDone;
  logic [DQM_W-1:0]  sdDqm;
  logic [BANK_W-1:0] sdBank;
  logic [ADDR_W-1:0] sdAddr;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  sdram_powerup_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_RSC(T_RSC), .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .DQM_W(DQM_W), .MODE_VALUE(MODE)
  ) dut_i (
    .clk(clk), .rst(rst), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdCke(sdCke), .sdDqm(sdDqm), .sdBank(sdBank),
    .sdAddr(sdAddr), .initDone(initDone)
  );

  function automatic logic [3:0] curCmd();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  function automatic logic [3:0] expCmd(int k);
    for (int i = 0; i < NEV; i++) if (EV_CYC[i] == k) return EV_CMD[i];
    return NOP;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // reset idle-state check (R1), then release on a falling edge
  task automatic doReset(int holdCycles, string tag);
    rst = 1'b1;
    for (int i = 0; i < holdCycles; i++) begin
      @(negedge clk);
      check(curCmd() == NOP, {tag, " cmd in reset"}, curCmd(), NOP);
      check(initDone == 1'b0, {tag, " ready in reset"}, initDone, 0);
      check(sdCke && sdDqm == '1, {tag, " R1 cke/dqm in reset"}, {sdCke, sdDqm}, 3'b111);
    end
    rst = 1'b0;
  endtask

  // walk cycles 1..lastCyc after reset release
  task automatic walk(int lastCyc, bit restarted);
    for (int k = 1; k <= lastCyc; k++) begin
      logic [3:0] e;
      string tag;
      @(negedge clk);
      e = expCmd(k);
      if (k < PAUSE_CYC)  tag = "R2 pause NOP";
      else if (e == PRE)  tag = "R4 precharge-all";
      else if (e == REF)  tag = "R5 auto-refresh";
      else if (e == MRS)  tag = "R6 mode load";
      else                tag = "R7 NOP between";
      check(curCmd() == e, tag, curCmd(), e);
      if (e == PRE) check(sdAddr[10] == 1'b1, "R4 A10", sdAddr, 12'h400);
      if (e == MRS) begin
        check(sdAddr == MODE, "R6 mode word", sdAddr, MODE);
        check(sdBank == '0, "R6 bank zero", sdBank, 0);
      end
      if (restarted && k == PAUSE_CYC)
        check(curCmd() == PRE, "R9 restart precharge", curCmd(), PRE);
      check(sdCke && sdDqm == '1, "R3 cke/dqm high", {sdCke, sdDqm}, 3'b111);
      check(initDone == (k >= DONE_CYC), "R8 ready", initDone, (k >= DONE_CYC));
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // run 1: full sequence and long quiet tail after ready
    doReset(3, "R1");
    walk(DONE_CYC + 30, 1'b0);

    // run 2: reset after ready drops it and restarts (R9)
    doReset(1, "R9");
    walk(45, 1'b0);

    // run 3: reset in the middle of the refresh train (R9)
    doReset(1, "R9 mid");
    walk(DONE_CYC + 10, 1'b1);

    summary();
  end

endmodule